// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block is the counting core of a real-time clock. It holds the current time and date as eight byte-wide BCD registers: hundredths of a second, seconds, minutes, hours, day of week, date, month with a century flag, and year. A one-cycle pulse on `tick_i` at 100 Hz advances the hundredths. When a field rolls over, it carries into the next field, and carries can pass all the way up to the year and the century flag.

The hours register has two encodings, selected by its bit 6. One encoding is 24-hour time. The other is 12-hour time with an AM/PM flag. The date rolls over according to the length of the current month, and February gains a 29th day in years divisible by four.

A plain parallel port lets the host load or read any register by a 3-bit address. Reads are combinational. A write takes effect at the next clock edge. The block does not check whether written values are legal.

Top module: `bcd_clock_core`

## Requirements
- R1: After reset, the read port returns 00h for hundredths, seconds, minutes, hours and year, 01h for day, date and month, and the century bit is 0.
- R2: The addresses are 0 hundredths, 1 seconds, 2 minutes, 3 hours, 4 day of week, 5 date, 6 month and 7 year. In the month byte, bit 7 is the century bit and bits 4:0 are the BCD month; bits 6:5 read 0. Hours bit 7 reads 0. A write stores the byte, and a later read at the same address returns it.
- R3: Each tick advances hundredths from 00 to 99 and then wraps to 00 with a carry. Seconds and minutes count 00 to 59 and wrap with a carry to the next field.
- R4: With hours bit 6 at 0 (24-hour mode), bits 5:4 are the tens digit and hours count 00 to 23. The step from 23 to 00 carries into day of week and date.
- R5: With hours bit 6 at 1 (12-hour mode), bit 5 is PM (1 = PM) and bit 4 is the tens digit. Hours run 12, 01 to 11, and back to 12. The step from 11 to 12 toggles PM, and it carries into day and date only when PM goes from 1 to 0.
- R6: Day of week advances on each midnight carry and wraps from 07 to 01.
- R7: Date wraps to 01 after the last day of the month: 31 days, 30 for months 04, 06, 09 and 11, and 28 for 02, or 29 when the BCD year is divisible by 4. The wrap advances the month, and month 12 wraps to 01 with a carry into the year.
- R8: When the year steps from 99 to 00, the century bit (month bit 7) toggles.
- R9: A write to a register in the same cycle as an advance stores the written value. All other registers advance as they would without the write.
- R10: With no tick and no write, every register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick_i | input | 1 | One-cycle 100 Hz advance pulse |
| wr_en_i | input | 1 | Write strobe for the addressed register |
| addr_i | input | 3 | Register address for read and write |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Contents of the addressed register (combinational) |

## Verification
The bench aims at the long carry chains:
- The New Year's Eve step from 23:59:59.99 on 31 December of year 99 must clear every field and flip the century bit. A broken link in the chain leaves some field stale.
- In 12-hour mode, the 11-to-12 steps must toggle PM, and only the 11 PM step may advance the day. A design that carries on 11 AM, or at 12 to 01, moves the date twice a day.
- Month-end steps on 30-day months and on February in leap and common years catch a design that uses a fixed month length or a binary leap test on BCD digits.
- A write that lands together with a tick checks that the write wins while the rest of the chain still advances.

The constrained random part loads legal values and runs bursts of ticks, comparing all registers against a bench model.

// File: rtl/bcd_clock_pkg.sv
package bcd_clock_pkg;

  localparam int REG_W    = 8;
  localparam int NUM_REGS = 8;
  localparam int ADDR_W   = $clog2(NUM_REGS);

  typedef enum logic [ADDR_W-1:0] {
    ADDR_HUND  = 3'd0,
    ADDR_SEC   = 3'd1,
    ADDR_MIN   = 3'd2,
    ADDR_HOUR  = 3'd3,
    ADDR_DAY   = 3'd4,
    ADDR_DATE  = 3'd5,
    ADDR_MONTH = 3'd6,
    ADDR_YEAR  = 3'd7
  } reg_addr_e;

  localparam logic [REG_W-1:0] BCD_00 = 8'h00;
  localparam logic [REG_W-1:0] BCD_01 = 8'h01;
  localparam logic [REG_W-1:0] BCD_07 = 8'h07;
  localparam logic [REG_W-1:0] BCD_12 = 8'h12;
  localparam logic [REG_W-1:0] BCD_59 = 8'h59;
  localparam logic [REG_W-1:0] BCD_99 = 8'h99;

  // Last BCD date of a month; leap test works on the two BCD year digits.
  function automatic logic [REG_W-1:0] last_date(input logic [REG_W-1:0] mon,
                                                 input logic [REG_W-1:0] yr);
    logic leap;
    leap = yr[4] ? ((yr[3:0] == 4'd2) || (yr[3:0] == 4'd6))
                 : ((yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8));
    case (mon)
      8'h02:                      last_date = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_date = 8'h30;
      default:                    last_date = 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/bcd_field.sv
module bcd_field #(
  parameter int             W   = 8,
  parameter logic [W-1:0]   MIN = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         wr_i,
  input  logic [W-1:0] wr_data_i,
  input  logic [W-1:0] max_i,
  output logic [W-1:0] val_o,
  output logic         carry_o
);

  localparam logic [W-5:0] TENS_ONE = 1;

  logic [W-1:0] val_q, val_d, inc_val;
  logic         at_max;

  always_comb begin
    at_max = (val_q == max_i);
    if (at_max) begin
      inc_val = MIN;
    end else if (val_q[3:0] == 4'h9) begin
      inc_val = {val_q[W-1:4] + TENS_ONE, 4'h0};
    end else begin
      inc_val = {val_q[W-1:4], val_q[3:0] + 4'h1};
    end
    if (wr_i) begin
      val_d = wr_data_i;
    end else if (inc_i) begin
      val_d = inc_val;
    end else begin
      val_d = val_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q <= MIN;
    end else begin
      val_q <= val_d;
    end
  end

  assign val_o   = val_q;
  assign carry_o = inc_i & at_max;

endmodule

// File: rtl/hour_field.sv
module hour_field (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       inc_i,
  input  logic       wr_i,
  input  logic [6:0] wr_data_i,
  output logic [6:0] hr_o,
  output logic       carry_o
);

  logic [6:0] hr_q, hr_d, inc_val;
  logic       wrap;

  always_comb begin
    inc_val = hr_q;
    wrap    = 1'b0;
    if (!hr_q[6]) begin
      // 24-hour: bits 5:4 tens, 3:0 ones
      if (hr_q[5:0] == 6'h23) begin
        inc_val[5:0] = 6'h00;
        wrap         = 1'b1;
      end else if (hr_q[3:0] == 4'h9) begin
        inc_val[5:0] = {hr_q[5:4] + 2'd1, 4'h0};
      end else begin
        inc_val[3:0] = hr_q[3:0] + 4'h1;
      end
    end else begin
      // 12-hour: bit 5 PM, bit 4 tens, 3:0 ones
      if (hr_q[4:0] == 5'h11) begin
        inc_val[4:0] = 5'h12;
        inc_val[5]   = ~hr_q[5];
        wrap         = hr_q[5];
      end else if (hr_q[4:0] == 5'h12) begin
        inc_val[4:0] = 5'h01;
      end else if (hr_q[3:0] == 4'h9) begin
        inc_val[4:0] = 5'h10;
      end else begin
        inc_val[3:0] = hr_q[3:0] + 4'h1;
      end
    end
    if (wr_i) begin
      hr_d = wr_data_i;
    end else if (inc_i) begin
      hr_d = inc_val;
    end else begin
      hr_d = hr_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hr_q <= 7'h00;
    end else begin
      hr_q <= hr_d;
    end
  end

  assign hr_o    = hr_q;
  assign carry_o = inc_i & wrap;

endmodule

// File: rtl/bcd_clock_core.sv
module bcd_clock_core
  import bcd_clock_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wr_data_i,
  output logic [REG_W-1:0]  rd_data_o
);

  // reset: asynchronous assert, synchronous release
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [NUM_REGS-1:0] wr_sel;
  for (genvar k = 0; k < NUM_REGS; k++) begin : g_wsel
    assign wr_sel[k] = wr_en_i && (addr_i == k[ADDR_W-1:0]);
  end

  logic [REG_W-1:0] hund_q, sec_q, min_q, day_q, date_q, mon_q, year_q, date_max;
  logic [6:0]       hr_q;
  logic             c_hund, c_sec, c_min, c_hr, c_day, c_date, c_mon, c_year;
  logic             cent_q, cent_d;

  bcd_field #(.W(REG_W), .MIN(BCD_00)) u_hund (
    .clk_i, .rst_ni(rst_sync_q), .inc_i(tick_i), .wr_i(wr_sel[ADDR_HUND]),
    .wr_data_i, .max_i(BCD_99), .val_o(hund_q), .carry_o(c_hund));

  bcd_field #(.W(REG_W), .MIN(BCD_00)) u_sec (
    .clk_i, .rst_ni(rst_sync_q), .inc_i(c_hund), .wr_i(wr_sel[ADDR_SEC]),
    .wr_data_i, .max_i(BCD_59), .val_o(sec_q), .carry_o(c_sec));

  bcd_field #(.W(REG_W), .MIN(BCD_00)) u_min (
    .clk_i, .rst_ni(rst_sync_q), .inc_i(c_sec), .wr_i(wr_sel[ADDR_MIN]),
    .wr_data_i, .max_i(BCD_59), .val_o(min_q), .carry_o(c_min));

  hour_field u_hour (
    .clk_i, .rst_ni(rst_sync_q), .inc_i(c_min), .wr_i(wr_sel[ADDR_HOUR]),
    .wr_data_i(wr_data_i[6:0]), .hr_o(hr_q), .carry_o(c_hr));

  bcd_field #(.W(REG_W), .MIN(BCD_01)) u_day (
    .clk_i, .rst_ni(rst_sync_q), .inc_i(c_hr), .wr_i(wr_sel[ADDR_DAY]),
    .wr_data_i, .max_i(BCD_07), .val_o(day_q), .carry_o(c_day));

  assign date_max = last_date(mon_q, year_q);

  bcd_field #(.W(REG_W), .MIN(BCD_01)) u_date (
    .clk_i, .rst_ni(rst_sync_q), .inc_i(c_hr), .wr_i(wr_sel[ADDR_DATE]),
    .wr_data_i, .max_i(date_max), .val_o(date_q), .carry_o(c_date));

  bcd_field #(.W(REG_W), .MIN(BCD_01)) u_month (
    .clk_i, .rst_ni(rst_sync_q), .inc_i(c_date), .wr_i(wr_sel[ADDR_MONTH]),
    .wr_data_i({3'b000, wr_data_i[4:0]}), .max_i(BCD_12), .val_o(mon_q),
    .carry_o(c_mon));

  bcd_field #(.W(REG_W), .MIN(BCD_00)) u_year (
    .clk_i, .rst_ni(rst_sync_q), .inc_i(c_mon), .wr_i(wr_sel[ADDR_YEAR]),
    .wr_data_i, .max_i(BCD_99), .val_o(year_q), .carry_o(c_year));

  always_comb begin
    if (wr_sel[ADDR_MONTH]) begin
      cent_d = wr_data_i[REG_W-1];
    end else if (c_year) begin
      cent_d = ~cent_q;
    end else begin
      cent_d = cent_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      cent_q <= 1'b0;
    end else begin
      cent_q <= cent_d;
    end
  end

  always_comb begin
    case (addr_i)
      ADDR_HUND:  rd_data_o = hund_q;
      ADDR_SEC:   rd_data_o = sec_q;
      ADDR_MIN:   rd_data_o = min_q;
      ADDR_HOUR:  rd_data_o = {1'b0, hr_q};
      ADDR_DAY:   rd_data_o = day_q;
      ADDR_DATE:  rd_data_o = date_q;
      ADDR_MONTH: rd_data_o = {cent_q, 2'b00, mon_q[4:0]};
      default:    rd_data_o = year_q;
    endcase
  end

  logic unused_c;
  assign unused_c = c_day ^ (|mon_q[7:5]);

endmodule

// File: rtl/bcd_clock_chk.sv
module bcd_clock_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic       wr_en_i,
  input logic [2:0] addr_i,
  input logic [7:0] wr_data_i,
  input logic [7:0] hund_i,
  input logic [7:0] sec_i,
  input logic [7:0] min_i,
  input logic [6:0] hr_i,
  input logic       hr_inc_i,
  input logic [7:0] day_i,
  input logic       day_inc_i,
  input logic [7:0] date_i,
  input logic [7:0] mon_i,
  input logic [7:0] year_i,
  input logic       cent_i
);

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !wr_en_i) |=> ($stable(hund_i) && $stable(sec_i) && $stable(min_i)
      && $stable(hr_i) && $stable(day_i) && $stable(date_i) && $stable(mon_i)
      && $stable(year_i) && $stable(cent_i))); // R10

  AST_WRITE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 3'd0) |=> (hund_i == $past(wr_data_i))); // R9

  AST_HUND_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wr_en_i && hund_i == 8'h99) |=> (hund_i == 8'h00)); // R3

  AST_CENTURY_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && year_i == 8'h99) |=> ((year_i == 8'h00) == (cent_i != $past(cent_i)))); // R8

  AST_PM_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && hr_inc_i && hr_i[6] && hr_i[4:0] == 5'h11)
      |=> (hr_i[5] != $past(hr_i[5]) && hr_i[4:0] == 5'h12)); // R5

  AST_DAY_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && day_inc_i && day_i == 8'h07) |=> (day_i == 8'h01)); // R6

endmodule

bind bcd_clock_core bcd_clock_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_sync_q), .tick_i(tick_i), .wr_en_i(wr_en_i),
  .addr_i(addr_i), .wr_data_i(wr_data_i), .hund_i(hund_q), .sec_i(sec_q),
  .min_i(min_q), .hr_i(hr_q), .hr_inc_i(c_min), .day_i(day_q), .day_inc_i(c_hr),
  .date_i(date_q), .mon_i(mon_q), .year_i(year_q), .cent_i(cent_q));

// File: tb/test_bcd_clock_core.sv
`timescale 1ns/1ps
module test_bcd_clock_core;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick;
  logic       we;
  logic [2:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 0;
  logic [7:0] m [8];

  always #4 clk = ~clk;

  bcd_clock_core i_bcd_clock_core (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(we),
    .addr_i(addr), .wr_data_i(wdata), .rd_data_o(rdata));

  function automatic int b2i(input logic [7:0] v);
    return int'(v[7:4]) * 10 + int'(v[3:0]);
  endfunction

  function automatic logic [7:0] i2b(input int n);
    logic [7:0] r;
    r[7:4] = 4'(n / 10);
    r[3:0] = 4'(n % 10);
    return r;
  endfunction

  function automatic int mlen(input int mo, input int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic model_tick();
    int n; bit c; bit pm; bit cent; int mo; int yr; int dt;
    logic [7:0] hb;
    n = b2i(m[0]) + 1; c = (n == 100); m[0] = i2b(c ? 0 : n);
    if (c) begin n = b2i(m[1]) + 1; c = (n == 60); m[1] = i2b(c ? 0 : n); end
    if (c) begin n = b2i(m[2]) + 1; c = (n == 60); m[2] = i2b(c ? 0 : n); end
    if (c) begin
      if (!m[3][6]) begin
        n = int'(m[3][5:4]) * 10 + int'(m[3][3:0]) + 1;
        c = (n == 24);
        m[3] = i2b(c ? 0 : n);
      end else begin
        n = int'(m[3][4]) * 10 + int'(m[3][3:0]);
        pm = m[3][5]; c = 1'b0;
        if (n == 11) begin n = 12; c = pm; pm = ~pm; end
        else if (n == 12) n = 1;
        else n++;
        hb = i2b(n);
        m[3] = {1'b0, 1'b1, pm, hb[4:0]};
      end
    end
    if (c) begin
      n = b2i(m[4]) + 1; m[4] = i2b(n > 7 ? 1 : n);
      cent = m[6][7]; mo = b2i({3'b000, m[6][4:0]}); yr = b2i(m[7]);
      dt = b2i(m[5]) + 1;
      if (dt > mlen(mo, yr)) begin
        dt = 1; mo++;
        if (mo > 12) begin
          mo = 1; yr++;
          if (yr == 100) begin yr = 0; cent = ~cent; end
        end
      end
      m[5] = i2b(dt); hb = i2b(mo);
      m[6] = {cent, 2'b00, hb[4:0]}; m[7] = i2b(yr);
    end
  endtask

  task automatic model_write(input logic [2:0] a, input logic [7:0] d);
    if (a == 3'd3)      m[a] = {1'b0, d[6:0]};
    else if (a == 3'd6) m[a] = {d[7], 2'b00, d[4:0]};
    else                m[a] = d;
  endtask

  task automatic cyc(input bit tk, input bit w, input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    tick = tk; we = w; addr = a; wdata = d;
    @(posedge clk);
    if (tk) model_tick();
    if (w) model_write(a, d);
    @(negedge clk);
    tick = 1'b0; we = 1'b0;
  endtask

  task automatic check_all(input string req);
    for (int a = 0; a < 8; a++) begin
      addr = 3'(a);
      #1;
      n_chk++;
      if (rdata !== m[a]) begin
        n_fail++;
        $display("FAIL %s addr %0d: actual %h expected %h", req, a, rdata, m[a]);
      end
    end
  endtask

  task automatic load(input logic [7:0] v [8]);
    for (int a = 0; a < 8; a++) cyc(0, 1, 3'(a), v[a]);
  endtask

  function automatic logic [7:0] rand_val(input int a);
    logic [7:0] hb;
    case (a)
      0: return i2b(int'($urandom_range(0, 99)));
      1, 2: return i2b(int'($urandom_range(0, 59)));
      3: begin
        if ($urandom_range(0, 1) == 0) return i2b(int'($urandom_range(0, 23)));
        hb = i2b(int'($urandom_range(1, 12)));
        return {1'b0, 1'b1, 1'($urandom_range(0, 1)), hb[4:0]};
      end
      4: return i2b(int'($urandom_range(1, 7)));
      5: return i2b(int'($urandom_range(1, 28)));
      6: begin
        hb = i2b(int'($urandom_range(1, 12)));
        return {1'($urandom_range(0, 1)), 2'b00, hb[4:0]};
      end
      default: return i2b(int'($urandom_range(0, 99)));
    endcase
  endfunction

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual not finished, expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v [8];
    void'($urandom(32'd20240611));
    rst_n = 1'b0; tick = 1'b0; we = 1'b0; addr = 3'd0; wdata = 8'h00;
    m = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R1 reset");

    // R4 R6 R7 R8: full chain rollover in 24-hour mode
    v = '{8'h99, 8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99};
    load(v);
    check_all("R2 load");
    cyc(1, 0, 0, 0);
    check_all("R4 R6 R7 R8 new year");

    // R5: 11 PM -> 12 AM advances day; 11 AM -> 12 PM does not; 12 -> 01
    v = '{8'h99, 8'h59, 8'h59, 8'h71, 8'h03, 8'h15, 8'h05, 8'h21};
    load(v);
    cyc(1, 0, 0, 0);
    check_all("R5 pm to am");
    v = '{8'h99, 8'h59, 8'h59, 8'h51, 8'h03, 8'h15, 8'h05, 8'h21};
    load(v);
    cyc(1, 0, 0, 0);
    check_all("R5 am to pm");
    cyc(0, 1, 1, 8'h59); cyc(0, 1, 2, 8'h59); cyc(0, 1, 0, 8'h99);
    cyc(1, 0, 0, 0);
    check_all("R5 twelve to one");

    // R7: leap and common February, 30-day month
    v = '{8'h99, 8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h24};
    load(v); cyc(1, 0, 0, 0);
    check_all("R7 leap feb28");
    v[7] = 8'h23;
    load(v); cyc(1, 0, 0, 0);
    check_all("R7 common feb28");
    v[5] = 8'h29; v[7] = 8'h00;
    load(v); cyc(1, 0, 0, 0);
    check_all("R7 leap feb29");
    v[5] = 8'h30; v[6] = 8'h04;
    load(v); cyc(1, 0, 0, 0);
    check_all("R7 april30");

    // R3 and R9: write to seconds while the tick carries into seconds
    v = '{8'h99, 8'h59, 8'h10, 8'h05, 8'h02, 8'h10, 8'h03, 8'h30};
    load(v);
    cyc(1, 1, 1, 8'h30);
    check_all("R9 R3 write with tick");

    // R10: idle cycles change nothing
    repeat (10) @(negedge clk);
    check_all("R10 idle hold");

    // R2 R3: random loads and tick bursts
    for (int it = 0; it < 250; it++) begin
      if ($urandom_range(0, 2) == 0) begin
        int a = int'($urandom_range(0, 7));
        cyc(0, 1, 3'(a), rand_val(a));
      end else begin
        int nt = int'($urandom_range(1, 120));
        for (int t = 0; t < nt; t++) cyc(1, 0, 0, 0);
      end
      if (it % 10 == 0) check_all("R2 R3 random");
    end
    check_all("R2 R3 random final");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule